// File: doc/BRIEF.md
# Programmable RAM-Pattern Memory Sequencer

This block drives the control pins of an external memory or peripheral from words that software stores in a small pattern RAM. It does not use a state machine built for one memory type. When a bus master raises a request, the block takes the access kind, picks a fixed starting slot in the RAM for that kind, and then reads one word per clock from consecutive slots. Each word sets the byte-select lines, a small set of general-purpose outputs, whether the row or the column half of the address is shown, whether the address steps forward, and whether the master gets a transfer acknowledge.

A sequence runs until it reaches a word with its end flag set. While a sequence runs, the block reports busy. A new request is held off until the sequence ends, and the pattern RAM refuses writes. Software loads the RAM through a simple write port when the block is idle.

Top module: `pseq_sequencer`

## Requirements
- R1: After reset and in every idle cycle, busy, ack, byte-select, general-purpose outputs and the memory address are all zero.
- R2: A request taken when idle starts the pattern in the next cycle at slot kind×(DEPTH/4). Kind 0 is a single read (slot 0), 1 a burst read (16), 2 a single write (32) and 3 a burst write (48).
- R3: While running, the block shows one pattern word per clock from consecutive slots. Word bits [7:0] drive the byte-select lines and bits [11:8] drive the general-purpose outputs.
- R4: Word bit 12 chooses the address half: 0 drives the row half, address bits [15:8]; 1 drives the column half, address bits [7:0].
- R5: Word bit 13 adds one to the held 16-bit address, wrapping at the top. The new value shows from the next cycle.
- R6: Word bit 14 pulses ack for that single cycle. A burst pattern with four ack words returns exactly four pulses, with the column stepping by one between beats.
- R7: Word bit 15 marks the final word. Busy is low in the cycle after it.
- R8: A pattern write (cfg_we, cfg_addr, cfg_wdata) made while idle is used by later sequences.
- R9: A pattern write made while busy is discarded, and the slot keeps its old contents.
- R10: A request raised while busy is stalled. It is accepted at the clock edge that ends the first idle cycle, and the running sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until accepted |
| req_kind | input | 2 | Access kind: 0 single read, 1 burst read, 2 single write, 3 burst write |
| req_addr | input | ADDR_W | Access start address |
| busy | output | 1 | Pattern running; new requests stall |
| ack | output | 1 | Transfer acknowledge pulse |
| mem_addr | output | ADDR_W/2 | Row or column half of the current address |
| bsel | output | 8 | Byte-select lines |
| gpo | output | 4 | General-purpose output lines |
| cfg_we | input | 1 | Pattern RAM write enable |
| cfg_addr | input | log2(DEPTH) | Pattern RAM slot |
| cfg_wdata | input | 16 | Pattern word to store |

## Verification
Every pattern cycle drives its word straight to the pins. A wrong pointer, a wrong dispatch slot or a pattern that ends early therefore shows up as a wrong byte-select, output or ack value in that same cycle. A fault in the held address shows up in the next cycle that selects the column or row half, so a burst across a 256-word boundary exposes a missing carry within one beat. A write that slips through while busy can stay hidden until that slot is run again, so the bench replays the affected pattern after such a write.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   localparam int BSEL_W = 8;
   localparam int GPO_W  = 4;
   localparam int WORD_W = BSEL_W + GPO_W + 4;

   // Pattern word layout, MSB first: end, ack, step, column, outputs, byte-selects
   typedef struct packed {
      logic              last;
      logic              ack;
      logic              step;
      logic              col;
      logic [GPO_W-1:0]  gpo;
      logic [BSEL_W-1:0] bsel;
   } pat_word_t;

   typedef enum logic [1:0] {
      KIND_RD_SINGLE = 2'd0,
      KIND_RD_BURST  = 2'd1,
      KIND_WR_SINGLE = 2'd2,
      KIND_WR_BURST  = 2'd3
   } acc_kind_t;

endpackage

// File: rtl/pseq_pattern_ram.sv
module pseq_pattern_ram
   import pseq_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_lock,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pseq_pattern_ram: DEPTH must be a power of two of at least 8");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en && !wr_lock) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   // A locked write must leave each slot untouched
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_guard
         assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_lock && wr_addr == AW'(g)) |=> $stable(mem[g]))
            else $error("pattern slot changed during a run");
      end
   endgenerate

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
   import pseq_pkg::*;
#(
   parameter  int DEPTH  = 64,
   localparam int AW     = $clog2(DEPTH),
   localparam int SLOT_W = AW - 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_kind,
   input  logic          word_last,
   output logic          running,
   output logic          accept,
   output logic [AW-1:0] ptr
);

   logic [AW-1:0] start_ptr;

   // Each access kind owns one quarter of the pattern RAM
   assign start_ptr = {req_kind, {SLOT_W{1'b0}}};
   assign accept    = req_valid && !running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         ptr     <= '0;
      end else if (accept) begin
         running <= 1'b1;
         ptr     <= start_ptr;
      end else if (running) begin
         ptr <= ptr + 1'b1;
         if (word_last) running <= 1'b0;
      end
   end

   assert_dispatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !running) |=> (running && ptr[AW-1 -: 2] == $past(req_kind)
                                   && ptr[SLOT_W-1:0] == '0))
      else $error("dispatch slot wrong");

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !word_last) |=> (running && ptr == $past(ptr) + 1'b1))
      else $error("pattern pointer did not advance");

   assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && word_last) |=> !running)
      else $error("sequence ran past its final word");

endmodule

// File: rtl/pseq_addr_path.sv
module pseq_addr_path #(
   parameter  int ADDR_W = 16,
   localparam int HALF   = ADDR_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              run,
   input  logic              step,
   input  logic              col_sel,
   output logic [HALF-1:0]   mem_addr
);

   generate
      if (ADDR_W < 4 || (ADDR_W % 2) != 0) begin : g_bad_width
         $error("pseq_addr_path: ADDR_W must be even and at least 4");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [HALF-1:0]   row_half, col_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            addr_q <= '0;
      else if (load)         addr_q <= load_addr;
      else if (run && step)  addr_q <= addr_q + 1'b1;
   end

   assign row_half = addr_q[ADDR_W-1:HALF];
   assign col_half = addr_q[HALF-1:0];

   always_comb begin
      if (!run)         mem_addr = '0;
      else if (col_sel) mem_addr = col_half;
      else              mem_addr = row_half;
   end

   assert_increment_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step) |=> (addr_q == $past(addr_q) + 1'b1))
      else $error("address did not step");

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(addr_q))
      else $error("address moved without a step bit");

endmodule

// File: rtl/pseq_sequencer.sv
module pseq_sequencer
   import pseq_pkg::*;
#(
   parameter  int ADDR_W = 16,
   parameter  int DEPTH  = 64,
   localparam int AW     = $clog2(DEPTH),
   localparam int HALF   = ADDR_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              ack,
   output logic [HALF-1:0]   mem_addr,
   output logic [BSEL_W-1:0] bsel,
   output logic [GPO_W-1:0]  gpo,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata
);

   logic              running;
   logic              accept;
   logic [AW-1:0]     ptr;
   logic [WORD_W-1:0] rd_data;
   pat_word_t         word;

   pseq_pattern_ram #(.DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_lock (running),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .rd_addr (ptr),
      .rd_data (rd_data)
   );

   assign word = pat_word_t'(rd_data);

   pseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .word_last (word.last),
      .running   (running),
      .accept    (accept),
      .ptr       (ptr)
   );

   pseq_addr_path #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (req_addr),
      .run       (running),
      .step      (word.step),
      .col_sel   (word.col),
      .mem_addr  (mem_addr)
   );

   // Pattern bits reach the pins only while a sequence runs
   assign busy = running;
   assign ack  = running & word.ack;
   assign bsel = running ? word.bsel : '0;
   assign gpo  = running ? word.gpo  : '0;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ack && bsel == '0 && gpo == '0 && mem_addr == '0))
      else $error("pins active while idle");

endmodule

// File: tb/pseq_sequencer_test.sv
module pseq_sequencer_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [15:0] req_addr = '0;
   logic        busy, ack;
   logic [7:0]  mem_addr;
   logic [7:0]  bsel;
   logic [3:0]  gpo;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] model [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   pseq_sequencer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .busy(busy), .ack(ack), .mem_addr(mem_addr),
      .bsel(bsel), .gpo(gpo), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] mk(bit last, bit ackb, bit stp, bit col,
                                      logic [3:0] g, logic [7:0] b);
      return {last, ackb, stp, col, g, b};
   endfunction

   task automatic idle_check(string tag);
      chk({tag, " busy"}, busy, 0);
      chk({tag, " ack"}, ack, 0);
      chk({tag, " bsel"}, bsel, 0);
      chk({tag, " gpo"}, gpo, 0);
      chk({tag, " mem_addr"}, mem_addr, 0);
   endtask

   task automatic write_slot(int a, logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic issue(int t, logic [15:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(t); req_addr = a;
   endtask

   // Follows a sequence accepted at the last edge, checking every pattern cycle
   task automatic follow(int t, logic [15:0] a, bit hold, int nt, logic [15:0] na,
                         bit wr, int wa, logic [15:0] wd, output int acks);
      int k = 0;
      bit fin = 0;
      logic [15:0] cur = a;
      logic [15:0] w;
      acks = 0;
      while (!fin) begin
         @(negedge clk);
         if (k == 0) begin
            if (hold) begin req_kind = 2'(nt); req_addr = na; end
            else req_valid = 1'b0;
            if (wr) begin cfg_we = 1'b1; cfg_addr = 6'(wa); cfg_wdata = wd; end
         end else if (k == 1) begin
            cfg_we = 1'b0;
         end
         w = model[t*16 + k];
         chk(k == 0 ? "R2 first word busy" : "R10 busy while running", busy, 1);
         chk(k == 0 ? "R2 first word bsel" : "R3 bsel", bsel, w[7:0]);
         chk("R3 gpo", gpo, w[11:8]);
         chk("R6 ack", ack, w[14]);
         chk("R4 mem_addr", mem_addr, w[12] ? cur[7:0] : cur[15:8]);
         if (w[14]) acks++;
         if (w[13]) cur = cur + 16'd1;
         k++;
         if (w[15]) fin = 1;
      end
   endtask

   task automatic run_one(int t, logic [15:0] a);
      int acks;
      issue(t, a);
      follow(t, a, 0, 0, 16'h0, 0, 0, 16'h0, acks);
      chk("R6 ack count", acks, (t == 1 || t == 3) ? 4 : 1);
      @(negedge clk);
      idle_check("R7 idle after final word");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int acks;
      logic [15:0] addrs [5] = '{16'h0000, 16'h12FE, 16'hFFFF, 16'hA55A, 16'h00FF};
      for (int i = 0; i < 64; i++) model[i] = 16'h0;
      model[0] = mk(0, 0, 0, 0, 4'h1, 8'h00);
      model[1] = mk(1, 1, 0, 1, 4'h0, 8'hFF);
      model[16] = mk(0, 0, 0, 0, 4'h2, 8'h00);
      for (int i = 0; i < 4; i++)
         model[17 + i] = mk(i == 3, 1, 1, 1, 4'h4, 8'hF0 ^ 8'(i));
      model[32] = mk(0, 0, 0, 0, 4'h3, 8'h00);
      model[33] = mk(0, 0, 0, 1, 4'h5, 8'h0F);
      model[34] = mk(1, 1, 0, 1, 4'h5, 8'h0F);
      model[48] = mk(0, 0, 0, 0, 4'h1, 8'h00);
      model[49] = mk(0, 1, 1, 1, 4'h0, 8'h03);
      model[50] = mk(0, 1, 1, 1, 4'h0, 8'h0C);
      model[51] = mk(0, 0, 0, 0, 4'h6, 8'h00);
      model[52] = mk(0, 1, 1, 1, 4'h0, 8'h30);
      model[53] = mk(1, 1, 1, 1, 4'h0, 8'hC0);

      repeat (3) @(negedge clk);
      idle_check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1 after reset release");

      for (int i = 0; i < 64; i++) write_slot(i, model[i]);
      idle_check("R1 idle during load");

      // Sweep every access kind across address corners (R2..R7)
      for (int t = 0; t < 4; t++)
         for (int j = 0; j < 5; j++)
            run_one(t, addrs[j]);

      // R9: a write to slot 1 during a run is discarded
      issue(0, 16'h3456);
      follow(0, 16'h3456, 0, 0, 16'h0, 1, 1, 16'hC0AA, acks);
      chk("R9 ack count", acks, 1);
      @(negedge clk);
      idle_check("R9 idle");
      run_one(0, 16'h3456);

      // R8: an idle write changes the single-write pattern
      model[33] = mk(0, 0, 0, 0, 4'h9, 8'h3C);
      write_slot(33, model[33]);
      run_one(2, 16'h7788);

      // R10: request held across a running burst read, then a burst write follows
      issue(1, 16'h40FD);
      follow(1, 16'h40FD, 1, 3, 16'h01FF, 0, 0, 16'h0, acks);
      chk("R10 first ack count", acks, 4);
      @(negedge clk);
      chk("R10 idle gap busy", busy, 0);
      chk("R10 idle gap ack", ack, 0);
      follow(3, 16'h01FF, 0, 0, 16'h0, 0, 0, 16'h0, acks);
      chk("R10 stalled request ack count", acks, 4);
      @(negedge clk);
      idle_check("R10 idle after stalled request");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule